// File: doc/BRIEF.md
# Serial Frame Start Trigger

This block decides the cycle in which one channel of a serial audio port begins a transfer. It watches a frame sync line that has already been brought into the local clock domain, the start pulse of the opposite channel, the end-of-transfer pulse of its own channel and, for a receiver, each incoming data word. From these it raises a single-cycle start pulse according to a programmed 4-bit start condition.

The frame sync seen by the trigger logic is chosen from three lines: the channel's own sync, the receive-side sync or the transmit-side sync. A frame-edge setting picks which physical sync edge marks a new frame. It does this by inverting the view of the line, so every sync-based condition is expressed relative to the frame-marking edge. The block keeps a busy flag from each start until the channel reports done. Level-style conditions consult this flag, so they cannot retrigger in the middle of a transfer.

Top module: `frame_start_trigger`

## Requirements
- R1: While `rst_n` is low, `start` is 0 and the busy flag is cleared. The first sync sample taken after reset is never treated as an edge.
- R2: `start` is registered. A condition sampled at one rising clock edge shows as `start`=1 for exactly the following cycle.
- R3: Code 0 (continuous) fires when `own_done` is 1, or when the channel is idle. Consecutive done pulses give back-to-back starts.
- R4: Code 1 (follow peer) fires exactly when `peer_start` is 1, whether or not the channel is busy.
- R5: Codes 2 and 3 fire while the sync view is low (2) or high (3), but only when the channel is idle. The channel becomes busy with each start and idle after the cycle in which `own_done` is 1. A start in the same cycle as `own_done` keeps it busy.
- R6: Codes 4 and 5 fire on a falling (4) or rising (5) edge of the sync view, whether or not the channel is busy.
- R7: Code 6 fires on any change of the sync view, only while idle. Code 7 fires on either edge of the sync view at any time.
- R8: Code 8 fires when `cfg_is_rx`=1, `rx_valid`=1 and `rx_word` equals `cfg_cmp`, and only while the channel is idle. It never fires when `cfg_is_rx`=0.
- R9: Codes 9 to 15 never fire, whatever the other inputs do.
- R10: `cfg_sync_sel` picks the sync line: 0 the own line, 1 the receive line, 2 the transmit line, 3 the own line.
- R11: With `cfg_frame_edge`=0 the selected line is used as is. With 1 it is inverted, so a falling edge on the pin counts as rising and a low pin counts as high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 4 | Start condition code 0..15 |
| cfg_sync_sel | input | 2 | Sync line choice |
| cfg_frame_edge | input | 1 | 0: rising marks a frame, 1: falling marks a frame |
| cfg_is_rx | input | 1 | Channel is a receiver (enables compare start) |
| cfg_cmp | input | DW | Compare value for the match condition |
| fs_own | input | 1 | Channel's own synchronized frame sync |
| fs_rx | input | 1 | Synchronized receive-side frame sync |
| fs_tx | input | 1 | Synchronized transmit-side frame sync |
| peer_start | input | 1 | Start pulse of the opposite channel |
| own_done | input | 1 | End-of-transfer pulse of this channel |
| rx_word | input | DW | Received data word |
| rx_valid | input | 1 | `rx_word` is valid this cycle |
| start | output | 1 | One-cycle transfer start pulse |

## Verification
A stuck or wrongly cleared busy flag shows in the cycle after a level, toggle or compare condition. Such a condition should fire and stays silent, or it should stay silent and fires again, so a missing or extra `start` pulse appears one clock after the stimulus. A corrupted edge-history register shows as a false or missing pulse one clock after the sync view changes or holds. This includes the first sample after reset, which must not count as an edge. A wrong sync selection or polarity view shows on the first edge or level test made with that setting.

// File: rtl/fst_pkg.sv
package fst_pkg;

    typedef enum logic [3:0] {
        SM_CONT    = 4'd0,
        SM_PEER    = 4'd1,
        SM_LOW     = 4'd2,
        SM_HIGH    = 4'd3,
        SM_FALL    = 4'd4,
        SM_RISE    = 4'd5,
        SM_TOGGLE  = 4'd6,
        SM_ANYEDGE = 4'd7,
        SM_MATCH   = 4'd8
    } start_mode_e;

    typedef enum logic [1:0] {
        SS_OWN  = 2'd0,
        SS_RX   = 2'd1,
        SS_TX   = 2'd2,
        SS_OWN2 = 2'd3
    } sync_src_e;

    typedef struct packed {
        logic prev;
        logic vld;
    } edge_state_t;

    typedef struct packed {
        logic busy;
        logic start;
    } trig_state_t;

endpackage

// File: rtl/fst_sync_view.sv
module fst_sync_view
    import fst_pkg::*;
(
    input  logic [1:0] sel,
    input  logic       invert,
    input  logic       fs_own,
    input  logic       fs_rx,
    input  logic       fs_tx,
    output logic       view
);
    logic picked;

    always_comb begin
        unique case (sync_src_e'(sel))
            SS_RX:   picked = fs_rx;
            SS_TX:   picked = fs_tx;
            default: picked = fs_own;
        endcase
        view = picked ^ invert;
    end
endmodule

// File: rtl/fst_edge_detect.sv
module fst_edge_detect
    import fst_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cur,
    output logic rise,
    output logic fall
);
    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = cur;
        st_d.vld  = 1'b1;
        rise      = st_q.vld & cur & ~st_q.prev;
        fall      = st_q.vld & ~cur & st_q.prev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/fst_cond_eval.sv
module fst_cond_eval
    import fst_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [3:0]    mode,
    input  logic          view,
    input  logic          rise,
    input  logic          fall,
    input  logic          busy,
    input  logic          peer_start,
    input  logic          own_done,
    input  logic          is_rx,
    input  logic [DW-1:0] cmp,
    input  logic [DW-1:0] word,
    input  logic          word_vld,
    output logic          fire
);
    logic idle;
    logic hit;

    always_comb begin
        idle = ~busy;
        hit  = is_rx & word_vld & (word == cmp);
        unique case (mode)
            SM_CONT:    fire = own_done | idle;
            SM_PEER:    fire = peer_start;
            SM_LOW:     fire = idle & ~view;
            SM_HIGH:    fire = idle & view;
            SM_FALL:    fire = fall;
            SM_RISE:    fire = rise;
            SM_TOGGLE:  fire = idle & (rise | fall);
            SM_ANYEDGE: fire = rise | fall;
            SM_MATCH:   fire = idle & hit;
            default:    fire = 1'b0;
        endcase
    end
endmodule

// File: rtl/frame_start_trigger.sv
module frame_start_trigger
    import fst_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    cfg_mode,
    input  logic [1:0]    cfg_sync_sel,
    input  logic          cfg_frame_edge,
    input  logic          cfg_is_rx,
    input  logic [DW-1:0] cfg_cmp,
    input  logic          fs_own,
    input  logic          fs_rx,
    input  logic          fs_tx,
    input  logic          peer_start,
    input  logic          own_done,
    input  logic [DW-1:0] rx_word,
    input  logic          rx_valid,
    output logic          start
);
    logic        view;
    logic        rise;
    logic        fall;
    logic        fire;
    trig_state_t st_d, st_q;

    fst_sync_view u_view (
        .sel    (cfg_sync_sel),
        .invert (cfg_frame_edge),
        .fs_own (fs_own),
        .fs_rx  (fs_rx),
        .fs_tx  (fs_tx),
        .view   (view)
    );

    fst_edge_detect u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .cur   (view),
        .rise  (rise),
        .fall  (fall)
    );

    fst_cond_eval #(.DW(DW)) u_eval (
        .mode       (cfg_mode),
        .view       (view),
        .rise       (rise),
        .fall       (fall),
        .busy       (st_q.busy),
        .peer_start (peer_start),
        .own_done   (own_done),
        .is_rx      (cfg_is_rx),
        .cmp        (cfg_cmp),
        .word       (rx_word),
        .word_vld   (rx_valid),
        .fire       (fire)
    );

    // Start wins over done: a transfer launched in the done cycle keeps busy.
    always_comb begin
        st_d       = st_q;
        st_d.start = fire;
        if (fire)          st_d.busy = 1'b1;
        else if (own_done) st_d.busy = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign start = st_q.start;
endmodule

// File: rtl/fst_checker.sv
module fst_checker #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [3:0]    cfg_mode,
    input logic          cfg_is_rx,
    input logic          peer_start,
    input logic          own_done,
    input logic [DW-1:0] rx_word,
    input logic          start
);
    p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> !start);

    p_cont_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 4'd0 && own_done) |=> start);

    p_peer_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 4'd1 && peer_start) |=> start);

    p_peer_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 4'd1 && !peer_start) |=> !start);

    p_level_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_mode == 4'd2 || cfg_mode == 4'd3) && start) |=> !start);

    p_rx_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 4'd8 && !cfg_is_rx) |=> !start);

    p_reserved_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode >= 4'd9) |=> !start);

    logic unused_ok;
    assign unused_ok = ^rx_word;
endmodule

bind frame_start_trigger fst_checker #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_mode   (cfg_mode),
    .cfg_is_rx  (cfg_is_rx),
    .peer_start (peer_start),
    .own_done   (own_done),
    .rx_word    (rx_word),
    .start      (start)
);

// File: tb/frame_start_trigger_test.sv
module frame_start_trigger_test;
    localparam int DW = 16;
    localparam logic [DW-1:0] CMP = 16'hA5C3;

    typedef struct packed {
        int req; int mode; int sel; int fe; int own; int rx; int tx;
        int peer; int done; int isrx; int valid; int miss; int exp;
    } vec_t;

    localparam int NV = 43;
    //                req mode sel fe own rx tx peer done isrx valid miss exp
    localparam vec_t TBL [NV] = '{
        '{ 6, 5,0,0, 1,0,0, 0,0, 0,0,0, 0},  // R6 no edge
        '{ 6, 4,0,0, 0,0,0, 0,0, 0,0,0, 1},  // R6 falling
        '{ 6, 5,0,0, 1,0,0, 0,0, 0,0,0, 1},  // R6 rising while busy
        '{ 6, 5,0,0, 1,0,0, 0,1, 0,0,0, 0},  // R6 held high
        '{ 5, 3,0,0, 1,0,0, 0,0, 0,0,0, 1},  // R5 high, idle
        '{ 2, 3,0,0, 1,0,0, 0,0, 0,0,0, 0},  // R2 single pulse, busy
        '{ 5, 3,0,0, 1,0,0, 0,1, 0,0,0, 0},  // R5 busy until done
        '{ 5, 2,0,0, 1,0,0, 0,0, 0,0,0, 0},  // R5 low not met
        '{ 5, 2,0,0, 0,0,0, 0,0, 0,0,0, 1},  // R5 low, idle
        '{ 5, 2,0,0, 0,0,0, 0,1, 0,0,0, 0},  // R5 busy
        '{ 4, 1,0,0, 0,0,0, 1,0, 0,0,0, 1},  // R4 peer start
        '{ 4, 1,0,0, 0,0,0, 0,0, 0,0,0, 0},  // R4 no peer
        '{ 9,15,0,0, 1,0,0, 1,1, 1,1,0, 0},  // R9 code 15
        '{ 9, 9,0,0, 0,0,0, 1,0, 1,1,0, 0},  // R9 code 9
        '{ 8, 8,0,0, 0,0,0, 0,0, 1,1,0, 1},  // R8 match
        '{ 8, 8,0,0, 0,0,0, 0,0, 1,1,0, 0},  // R8 busy
        '{ 8, 8,0,0, 0,0,0, 0,1, 1,1,0, 0},  // R8 busy, done
        '{ 8, 8,0,0, 0,0,0, 0,0, 0,1,0, 0},  // R8 transmit side
        '{ 8, 8,0,0, 0,0,0, 0,0, 1,1,1, 0},  // R8 mismatch
        '{ 8, 8,0,0, 0,0,0, 0,0, 1,0,0, 0},  // R8 not valid
        '{ 3, 0,0,0, 0,0,0, 0,0, 0,0,0, 1},  // R3 idle start
        '{ 3, 0,0,0, 0,0,0, 0,0, 0,0,0, 0},  // R3 busy
        '{ 3, 0,0,0, 0,0,0, 0,1, 0,0,0, 1},  // R3 done
        '{ 3, 0,0,0, 0,0,0, 0,1, 0,0,0, 1},  // R3 back to back
        '{ 3, 0,0,0, 0,0,0, 0,0, 0,0,0, 0},  // R3 busy again
        '{ 7, 6,0,0, 1,0,0, 0,1, 0,0,0, 0},  // R7 toggle while busy
        '{ 7, 6,0,0, 0,0,0, 0,0, 0,0,0, 1},  // R7 toggle idle
        '{ 7, 7,0,0, 1,0,0, 0,0, 0,0,0, 1},  // R7 any edge rise
        '{ 7, 7,0,0, 0,0,0, 0,0, 0,0,0, 1},  // R7 any edge fall
        '{ 7, 7,0,0, 0,0,0, 0,1, 0,0,0, 0},  // R7 no change
        '{10, 5,1,0, 0,1,0, 0,0, 0,0,0, 1},  // R10 receive line
        '{10, 5,1,0, 0,1,0, 0,0, 0,0,0, 0},  // R10 held
        '{10, 5,2,0, 0,1,0, 0,0, 0,0,0, 0},  // R10 transmit line low
        '{10, 5,2,0, 0,0,1, 0,0, 0,0,0, 1},  // R10 transmit line rise
        '{10, 5,3,0, 1,0,0, 0,0, 0,0,0, 0},  // R10 code 3 = own
        '{10, 4,3,0, 0,0,0, 0,0, 0,0,0, 1},  // R10 own falling
        '{11, 5,0,1, 0,0,0, 0,0, 0,0,0, 1},  // R11 pin fall = rise
        '{11, 5,0,1, 1,0,0, 0,0, 0,0,0, 0},  // R11 pin rise ignored
        '{11, 5,0,1, 0,0,0, 0,0, 0,0,0, 1},  // R11 pin fall again
        '{11, 3,0,1, 0,0,0, 0,1, 0,0,0, 0},  // R11 busy
        '{11, 3,0,1, 0,0,0, 0,0, 0,0,0, 1},  // R11 low pin = high
        '{11, 2,0,1, 1,0,0, 0,1, 0,0,0, 0},  // R11 busy
        '{11, 2,0,1, 1,0,0, 0,0, 0,0,0, 1}   // R11 high pin = low
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    cfg_mode = 4'd15;
    logic [1:0]    cfg_sync_sel = 2'd0;
    logic          cfg_frame_edge = 1'b0;
    logic          cfg_is_rx = 1'b0;
    logic [DW-1:0] cfg_cmp = CMP;
    logic          fs_own = 1'b0;
    logic          fs_rx = 1'b0;
    logic          fs_tx = 1'b0;
    logic          peer_start = 1'b0;
    logic          own_done = 1'b0;
    logic [DW-1:0] rx_word = '0;
    logic          rx_valid = 1'b0;
    logic          start;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    frame_start_trigger #(.DW(DW)) uut (.*);

    task automatic check(input string tag, input logic exp);
        n_checks++;
        if (start !== exp) begin
            n_fail++;
            $display("FAIL %s: start=%b expected %b at %0t", tag, start, exp, $time);
        end
    endtask

    task automatic drive(input vec_t v);
        cfg_mode       = v.mode[3:0];
        cfg_sync_sel   = v.sel[1:0];
        cfg_frame_edge = v.fe[0];
        fs_own         = v.own[0];
        fs_rx          = v.rx[0];
        fs_tx          = v.tx[0];
        peer_start     = v.peer[0];
        own_done       = v.done[0];
        cfg_is_rx      = v.isrx[0];
        rx_valid       = v.valid[0];
        rx_word        = v.miss[0] ? (CMP ^ 16'h0001) : CMP;
    endtask

    initial begin
        // R1: reset holds start low even with a firing code
        rst_n = 1'b0; cfg_mode = 4'd5; fs_own = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 during reset", 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 first sample not an edge", 1'b0);

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i]);
            @(negedge clk);
            check($sformatf("R%0d vector %0d", TBL[i].req, i), TBL[i].exp[0]);
        end

        // R1: reset clears busy; channel is busy before this point
        rst_n = 1'b0; cfg_mode = 4'd3; cfg_frame_edge = 1'b0; fs_own = 1'b1;
        own_done = 1'b0; cfg_sync_sel = 2'd0;
        @(negedge clk);
        check("R1 start low in reset", 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy cleared by reset", 1'b1);
        @(negedge clk);
        check("R2 one cycle wide", 1'b0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule